// File: doc/BRIEF.md
# Switch-Selectable Edge-Count Divider

This block takes a slow periodic signal from outside the chip, such as a display polarity line, and produces a copy of it divided by a power of two. A set of panel switches supplies a select code that chooses the division ratio. The outside signal never drives the clock pin of any flip-flop. Every register is clocked by the main system clock.

The outside signal first passes through a two-flop synchroniser. A further register delays it by one clock. Comparing the current sample with the delayed one finds each rising edge of the outside signal. Each rising edge becomes a single-cycle enable pulse, and that pulse advances a free-running 9-bit counter. Counter bit n toggles at the input frequency divided by 2^(n+1). The select code either passes the synchronised input straight through or picks one counter bit. A register drives the chosen value onto the output.

The block suits a board where a front-panel setting selects the divide ratio for a refresh-related strobe. The outside signal only needs to stay in each state for two system clocks.

Top module: `ext_div_sel`

## Requirements
- R1: The outside input passes through a two-stage synchroniser, and each stage copies the previous one on every clock. A rising edge driven between clock edges raises the enable pulse after the second clock edge, moves the counter after the third and reaches the output after the fourth.
- R2: Each rising edge of the synchronised input makes an enable pulse exactly one clock wide. A high or low level of any length adds no further counts.
- R3: The edge counter is 9 bits wide. It adds one in each cycle with an enable pulse and holds its value in every other cycle. After 512 rising edges it wraps from 511 back to 0.
- R4: Select code 0 drives the output with the synchronised input level.
- R5: Select code k, for k from 1 to 9, drives the output with counter bit k-1. That output toggles once every 2^(k-1) rising edges, so its frequency is the input frequency divided by 2^k.
- R6: Select codes 10 to 15 drive the output low.
- R7: While the active-low reset is low at a clock edge, the synchroniser, the delay register, the counter and the output register are all cleared to 0. Counting starts again from 0 once reset is released.
- R8: Every rising edge is counted when the input stays high for at least two clocks and low for at least two clocks.
- R9: The output is registered. A change of select code appears on the output after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main system clock; the only clock in the block |
| rst_n | input | 1 | Synchronous reset, active low |
| ext_sig | input | 1 | Slow outside periodic signal, asynchronous to clk |
| tap_sel | input | 4 | Switch select code: 0 = pass-through, 1..9 = divide by 2^k, other codes = output low |
| div_out | output | 1 | Registered divided signal |

## Verification
A rising edge on the input is counted at the third clock edge after it is driven and shows on the output at the fourth. A falling edge on the pass-through path reaches the output at the third clock edge. Select-code changes take one clock edge. The bench therefore holds each input phase for six clocks and samples at the falling clock edge five clocks after each input transition. By then every register in the path has settled, and the next input change has not yet arrived. For each select code, the expected output after m rising edges since reset is computed as bit k-1 of m modulo 512, or as the input level for code 0. The short-pulse, wrap and select-switch checks use the same timing rule, with samples taken one clock after the select code changes.

// File: rtl/div_sel_pkg.sv
// Package: shared sizing defaults and helpers for the edge-count divider.
// Assumes: callers derive select-code widths through sel_width().
package div_sel_pkg;

    // Default edge counter width (number of divide taps).
    localparam int unsigned DEF_CNT_W = 9;

    // Default number of synchroniser flops ahead of edge detection.
    localparam int unsigned DEF_SYNC_STAGES = 2;

    // Width of a select code able to address CNT_W taps plus pass-through.
    function automatic int unsigned sel_width(input int unsigned cnt_w);
        return $clog2(cnt_w + 1);
    endfunction

endpackage

// File: rtl/sig_sync.sv
// Module: sig_sync
// Purpose: brings an asynchronous single-bit level into the clk domain
//          through a chain of STAGES flops.
// Assumes: STAGES >= 2; the input is a level, not a pulse shorter than clk.
module sig_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain_q;

    // Shift the raw level along the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_in};
        end
    end

    assign sync_out = chain_q[STAGES-1];

    // R1
    stage_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> chain_q[1] == $past(chain_q[0]));

endmodule

// File: rtl/rise_detect.sv
// Module: rise_detect
// Purpose: holds the synchronised level for one clock and flags the cycle
//          in which the current sample is high and the held one is low.
// Assumes: lvl_in is already in the clk domain.
module rise_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_in,
    output logic rise_pulse
);

    logic lvl_prev_q;

    // Keep the previous synchronised sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_prev_q <= 1'b0;
        end else begin
            lvl_prev_q <= lvl_in;
        end
    end

    // Current high, previous low: a rising edge this cycle.
    always_comb begin
        rise_pulse = lvl_in & ~lvl_prev_q;
    end

    // R2
    pulse_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_pulse |=> !rise_pulse);

    // R2
    pulse_needs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_pulse |-> lvl_in);

endmodule

// File: rtl/edge_counter.sv
// Module: edge_counter
// Purpose: free-running CNT_W-bit counter advanced by single-cycle enables.
// Assumes: inc is synchronous to clk; wrap at 2^CNT_W is intended.
module edge_counter #(
    parameter int unsigned CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    logic [CNT_W-1:0] count_q;

    // Advance on each enable, hold otherwise; wraps naturally.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (inc) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign count = count_q;

    // R3
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(count_q));

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> count_q == CNT_W'($past(count_q) + 1'b1));

endmodule

// File: rtl/tap_mux.sv
// Module: tap_mux
// Purpose: picks the pass-through level or one counter bit by select code
//          and registers the choice onto the output.
// Assumes: sel is a static switch setting; no glitch-free switching needed.
module tap_mux #(
    parameter int unsigned CNT_W = 9,
    parameter int unsigned SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lvl_in,
    input  logic [CNT_W-1:0] count,
    input  logic [SEL_W-1:0] sel,
    output logic             tap_out
);

    localparam int unsigned TAPS = CNT_W + 1;

    logic [TAPS-1:0] tap_vec;
    logic            tap_nxt;
    logic            tap_q;

    assign tap_vec = {count, lvl_in};

    // Decode the select code; codes beyond the last tap give 0.
    always_comb begin
        tap_nxt = 1'b0;
        for (int i = 0; i < TAPS; i++) begin
            if (sel == SEL_W'(i)) begin
                tap_nxt = tap_vec[i];
            end
        end
    end

    // Register the selected tap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tap_q <= 1'b0;
        end else begin
            tap_q <= tap_nxt;
        end
    end

    assign tap_out = tap_q;

    // R6
    unused_code_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(sel) > int'(CNT_W)) |=> !tap_q);

    // R7
    reset_clears_out_chk: assert property (@(posedge clk)
        !rst_n |=> !tap_q);

endmodule

// File: rtl/ext_div_sel.sv
// Module: ext_div_sel
// Purpose: divides a slow outside signal by a switch-chosen power of two,
//          counting its rising edges entirely in the system clock domain.
// Assumes: each input phase lasts at least two clk periods.
module ext_div_sel #(
    parameter  int unsigned CNT_W       = div_sel_pkg::DEF_CNT_W,
    parameter  int unsigned SYNC_STAGES = div_sel_pkg::DEF_SYNC_STAGES,
    localparam int unsigned SEL_W       = div_sel_pkg::sel_width(CNT_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_sig,
    input  logic [SEL_W-1:0] tap_sel,
    output logic             div_out
);

    logic             sync_lvl;
    logic             rise_en;
    logic [CNT_W-1:0] edge_cnt;

    sig_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_sig),
        .sync_out (sync_lvl)
    );

    rise_detect rise_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl_in     (sync_lvl),
        .rise_pulse (rise_en)
    );

    edge_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (rise_en),
        .count (edge_cnt)
    );

    tap_mux #(.CNT_W(CNT_W), .SEL_W(SEL_W)) mux_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl_in  (sync_lvl),
        .count   (edge_cnt),
        .sel     (tap_sel),
        .tap_out (div_out)
    );

    // R7
    reset_clears_cnt_chk: assert property (@(posedge clk)
        !rst_n |=> edge_cnt == '0);

endmodule

// File: tb/ext_div_sel_tb_top.sv
module ext_div_sel_tb_top;

    localparam int CNT_W = 9;
    localparam int SEL_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ext_sig = 1'b0;
    logic [SEL_W-1:0] tap_sel = '0;
    logic             div_out;

    int n_tests = 0;
    int n_fail  = 0;
    int edges   = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    ext_div_sel dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .ext_sig (ext_sig),
        .tap_sel (tap_sel),
        .div_out (div_out)
    );

    task automatic check(input logic got, input logic exp, input string req);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: div_out=%0b expected %0b (sel=%0d edges=%0d)",
                     req, got, exp, tap_sel, edges);
        end
    endtask

    function automatic logic expect_out(input int sel, input int m, input logic lvl);
        if (sel == 0) return lvl;
        if (sel <= CNT_W) return logic'(((m % 512) >> (sel - 1)) & 1);
        return 1'b0;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n   = 1'b0;
        ext_sig = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        edges = 0;
    endtask

    // One slow period: six clocks high, six low, sampling late in each phase.
    task automatic slow_period(input string req);
        ext_sig = 1'b1;
        edges++;
        repeat (5) @(negedge clk);
        check(div_out, expect_out(int'(tap_sel), edges, 1'b1), req);
        @(negedge clk);
        ext_sig = 1'b0;
        repeat (5) @(negedge clk);
        check(div_out, expect_out(int'(tap_sel), edges, 1'b0), req);
        @(negedge clk);
    endtask

    // Shortest legal period: two clocks high, two low.
    task automatic fast_period();
        ext_sig = 1'b1;
        edges++;
        repeat (2) @(negedge clk);
        ext_sig = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        // R7 reset state
        do_reset();
        check(div_out, 1'b0, "R7 reset state");

        // Sweep every select code (R4, R5, R6, R2, R3 count per edge)
        for (int s = 0; s < 16; s++) begin
            int n;
            tap_sel = SEL_W'(s);
            do_reset();
            if (s >= 1 && s <= CNT_W) n = (1 << s) + 8;
            else n = 20;
            if (n < 20) n = 20;
            for (int e = 0; e < n; e++) begin
                if (s == 0) slow_period("R4 pass-through");
                else if (s <= CNT_W) slow_period("R5 divide tap");
                else slow_period("R6 unused code");
            end
        end

        // R1 latency: output for sel 1 rises exactly four clock edges after the input
        tap_sel = SEL_W'(1);
        do_reset();
        ext_sig = 1'b1;
        edges++;
        repeat (3) @(negedge clk);
        check(div_out, 1'b0, "R1 not before fourth edge");
        @(negedge clk);
        check(div_out, 1'b1, "R1 at fourth edge");
        ext_sig = 1'b0;
        repeat (6) @(negedge clk);

        // R7 mid-stream reset: count restarts from zero
        tap_sel = SEL_W'(3);
        do_reset();
        for (int e = 0; e < 5; e++) slow_period("R5 before reset");
        do_reset();
        check(div_out, 1'b0, "R7 mid-stream clear");
        for (int e = 0; e < 4; e++) slow_period("R7 restart count");

        // R8 minimum-width phases, R9 select switching, R3 wrap
        tap_sel = SEL_W'(5);
        do_reset();
        for (int e = 0; e < 48; e++) fast_period();
        repeat (6) @(negedge clk);
        check(div_out, 1'b1, "R8 short phases counted (bit4 of 48)");
        tap_sel = SEL_W'(6);
        @(negedge clk);
        check(div_out, 1'b1, "R9 select change one clock (bit5 of 48)");
        tap_sel = SEL_W'(1);
        @(negedge clk);
        check(div_out, 1'b0, "R9 select change one clock (bit0 of 48)");
        tap_sel = SEL_W'(9);
        for (int e = 0; e < 208; e++) fast_period();
        repeat (6) @(negedge clk);
        check(div_out, 1'b1, "R3 count 256 sets bit8");
        for (int e = 0; e < 255; e++) fast_period();
        repeat (6) @(negedge clk);
        check(div_out, 1'b1, "R3 count 511 keeps bit8");
        fast_period();
        repeat (6) @(negedge clk);
        check(div_out, 1'b0, "R3 wrap 511 to 0");
        for (int s = 1; s <= CNT_W; s++) begin
            tap_sel = SEL_W'(s);
            @(negedge clk);
            check(div_out, 1'b0, "R3 all bits zero after wrap");
        end

        done = 1'b1;
    end

    // Watchdog and summary
    initial begin
        int cyc = 0;
        while (!done && cyc < 190000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, cycles=%0d expected <190000", cyc);
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule